// File: doc/BRIEF.md
# Correctable Error Record Status Register

This block is a 32-bit status register that logs correctable errors raised by the integrity checker of a translation cache. The checker pulses a report strobe with an 8-bit error code. The register then holds a valid flag, an overflow flag, a two-bit correctable-error field and the code of the first error that software has not yet acknowledged.

Software reads the register and clears fields by writing ones to them. The clear rules are interlocked so that an error cannot be dropped before software has seen it. The overflow flag must go before, or together with, the correctable-error field. The correctable-error field must go before, or together with, the valid flag. A secure-configuration input decides whether non-secure software may reach the register at all.

Top module: `err_status_reg`

## Requirements
- R1: After reset the register reads 0x00000000.
- R2: An error report (strobe high for one cycle) sets the valid flag at bit 30 and sets the correctable-error field at bits 25:24 to binary 10. If that field was 00 when the report arrived, the report's code is stored in bits 7:0. Code 0x07 means tag corruption and 0x08 means data corruption.
- R3: A report that arrives while bits 25:24 are nonzero sets the overflow flag at bit 27. The stored code is left unchanged, so the earliest code is kept.
- R4: Writing 1 to bit 27 clears the overflow flag. Writing 0 to it has no effect.
- R5: Writing binary 11 to bits 25:24 clears the field, and bits 7:0 return to 0x00 in the same cycle. Any other written value leaves the field unchanged. The clear is also ignored while the overflow flag is set, unless the same write clears the overflow flag.
- R6: Writing 1 to bit 30 clears the valid flag. Writing 0 has no effect. The clear is ignored while bits 25:24 are nonzero, unless the same write clears them.
- R7: Bits 31, 29:28, 26 and 23:8 always read 0. Writes to those bits, and writes to bits 7:0, change nothing.
- R8: When the non-secure access enable is 0, a non-secure read returns 0 and a non-secure write has no effect.
- R9: When a report and a write occur in the same cycle, the report's set takes priority over any clear it conflicts with. If the field was busy, the overflow flag is set and the field and code stay as they were. If the field was clear, the new error is recorded.
- R10: Secure accesses always read the current contents and may always perform the writes above. Non-secure accesses behave the same way when the enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_strobe | input | 1 | Error report strobe |
| ev_code | input | 8 | Code of the reported error |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_nonsec | input | 1 | Access is non-secure |
| ns_allow | input | 1 | Secure configuration: non-secure access enabled |
| sw_rdata | output | 32 | Register read value for the current access attribute |

## Verification
Single reports from an empty register show that the code is captured. A second report shows that the earliest code is kept and the overflow flag rises. Writes that target one field at a time tell the interlocks apart from plain write-1-to-clear behaviour. Combined writes show that the clears chain when issued together. Writes of zeros, reserved ones and non-11 field values must leave the register unchanged. Non-secure accesses with the enable off and on separate the gating from the field logic. Reports that coincide with a full clear are tried both with the field busy and with it empty, which separates the overflow path from the fresh-capture path.

// File: rtl/err_status_reg.sv
module err_status_reg #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_strobe,
  input  logic [CODE_W-1:0] ev_code,
  input  logic              sw_wr,
  input  logic [31:0]       sw_wdata,
  input  logic              sw_nonsec,
  input  logic              ns_allow,
  output logic [31:0]       sw_rdata
);
  localparam int VBIT  = 30;
  localparam int OFBIT = 27;
  localparam int CELO  = 24;
  localparam logic [1:0] CE_SET = 2'b10;

  logic              v_q, of_q;
  logic [1:0]        ce_q;
  logic [CODE_W-1:0] code_q;

  logic denied, wr_ok, of_clr, ce_clr, v_clr, ce_busy;

  assign denied  = sw_nonsec && !ns_allow;
  assign wr_ok   = sw_wr && !denied;
  assign ce_busy = ce_q != 2'b00;
  assign of_clr  = wr_ok && sw_wdata[OFBIT];
  assign ce_clr  = wr_ok && (sw_wdata[CELO+1:CELO] == 2'b11) && (!of_q || of_clr);
  assign v_clr   = wr_ok && sw_wdata[VBIT] && (!ce_busy || ce_clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      of_q   <= 1'b0;
      ce_q   <= 2'b00;
      code_q <= '0;
    end else if (ev_strobe) begin
      v_q <= 1'b1;
      if (ce_busy) begin
        of_q <= 1'b1;
      end else begin
        of_q   <= of_q && !of_clr;
        ce_q   <= CE_SET;
        code_q <= ev_code;
      end
    end else begin
      if (v_clr)  v_q  <= 1'b0;
      if (of_clr) of_q <= 1'b0;
      if (ce_clr) begin
        ce_q   <= 2'b00;
        code_q <= '0;
      end
    end
  end

  logic [31:0] image;
  always_comb begin
    image = '0;
    image[VBIT] = v_q;
    image[OFBIT] = of_q;
    image[CELO+1:CELO] = ce_q;
    image[CODE_W-1:0] = code_q;
  end

  assign sw_rdata = denied ? '0 : image;
endmodule

module err_status_reg_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_strobe,
  input logic [CODE_W-1:0] ev_code,
  input logic              sw_wr,
  input logic              sw_nonsec,
  input logic              ns_allow,
  input logic [31:0]       sw_rdata,
  input logic              v_q,
  input logic              of_q,
  input logic [1:0]        ce_q,
  input logic [CODE_W-1:0] code_q
);
  assert_ce_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q == 2'b00 || ce_q == 2'b10);
  assert_event_records_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_strobe |=> v_q && ce_q == 2'b10);
  assert_first_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_strobe && ce_q == 2'b00 |=> code_q == $past(ev_code));
  assert_keep_earliest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_strobe && ce_q != 2'b00 |=> of_q && code_q == $past(code_q));
  assert_of_needs_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    of_q |-> ce_q != 2'b00);
  assert_code_zero_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q == 2'b00 |-> code_q == '0);
  assert_v_covers_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ce_q != 2'b00 |-> v_q);
  assert_ns_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_nonsec && !ns_allow |-> sw_rdata == 32'h0);
  assert_ns_write_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr && sw_nonsec && !ns_allow && !ev_strobe |=>
      $stable(v_q) && $stable(of_q) && $stable(ce_q) && $stable(code_q));
  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rdata & 32'hB4FF_FF00) == 32'h0);
endmodule

bind err_status_reg err_status_reg_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .ev_code(ev_code),
  .sw_wr(sw_wr), .sw_nonsec(sw_nonsec), .ns_allow(ns_allow),
  .sw_rdata(sw_rdata), .v_q(v_q), .of_q(of_q), .ce_q(ce_q), .code_q(code_q)
);

// File: tb/err_status_reg_tb.sv
module err_status_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_strobe = 1'b0;
  logic [7:0]  ev_code = '0;
  logic        sw_wr = 1'b0;
  logic [31:0] sw_wdata = '0;
  logic        sw_nonsec = 1'b0;
  logic        ns_allow = 1'b0;
  logic [31:0] sw_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        mon_ev;

  always #5 clk = ~clk;

  err_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .ev_code(ev_code),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .sw_nonsec(sw_nonsec),
    .ns_allow(ns_allow), .sw_rdata(sw_rdata)
  );

  initial begin
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (sw_rdata !== e) begin
          bad++;
          $display("FAIL %s: actual=%08h expected=%08h", t, sw_rdata, e);
        end
      end
    end
  end

  task automatic rd(input bit ns, input logic [31:0] e, input string t);
    sw_nonsec = ns;
    #1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    -> mon_ev;
    @(negedge clk);
    sw_nonsec = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d, input bit ns);
    sw_wr = 1'b1; sw_wdata = d; sw_nonsec = ns;
    @(negedge clk);
    sw_wr = 1'b0; sw_wdata = '0; sw_nonsec = 1'b0;
  endtask

  task automatic ev(input logic [7:0] c);
    ev_strobe = 1'b1; ev_code = c;
    @(negedge clk);
    ev_strobe = 1'b0; ev_code = '0;
  endtask

  task automatic both(input logic [7:0] c, input logic [31:0] d);
    ev_strobe = 1'b1; ev_code = c; sw_wr = 1'b1; sw_wdata = d;
    @(negedge clk);
    ev_strobe = 1'b0; ev_code = '0; sw_wr = 1'b0; sw_wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, 32'h0000_0000, "R1 reset value");

    ev(8'h07);
    rd(0, 32'h4200_0007, "R2 first report captured");
    ev(8'h08);
    rd(0, 32'h4A00_0007, "R3 overflow keeps earliest code");

    wr(32'h0300_0000, 0);
    rd(0, 32'h4A00_0007, "R5 field clear blocked by overflow");
    wr(32'h4000_0000, 0);
    rd(0, 32'h4A00_0007, "R6 valid clear blocked by busy field");
    wr(32'h0000_0000, 0);
    rd(0, 32'h4A00_0007, "R4 zero write no effect");
    wr(32'hB4FF_FFFF, 0);
    rd(0, 32'h4A00_0007, "R7 reserved and code writes ignored");

    wr(32'h0900_0000, 0);
    rd(0, 32'h4200_0007, "R4 overflow cleared, R5 value 01 ignored");
    wr(32'h0300_0000, 0);
    rd(0, 32'h4000_0000, "R5 field clear returns code to zero");
    wr(32'h4000_0000, 0);
    rd(0, 32'h0000_0000, "R6 valid clear after field empty");

    ev(8'h08);
    rd(0, 32'h4200_0008, "R2 data-corruption code captured");
    ev(8'h07);
    wr(32'h4B00_0000, 0);
    rd(0, 32'h0000_0000, "R10 secure combined clear");

    ev(8'h07);
    ns_allow = 1'b0;
    rd(1, 32'h0000_0000, "R8 non-secure read masked");
    wr(32'h4B00_0000, 1);
    rd(0, 32'h4200_0007, "R8 non-secure write ignored");
    ns_allow = 1'b1;
    rd(1, 32'h4200_0007, "R10 non-secure read enabled");
    wr(32'h4B00_0000, 1);
    rd(0, 32'h0000_0000, "R10 non-secure clear enabled");
    ns_allow = 1'b0;

    ev(8'h07);
    both(8'h08, 32'h4B00_0000);
    rd(0, 32'h4A00_0007, "R9 report beats clear on busy field");
    wr(32'h4B00_0000, 0);
    rd(0, 32'h0000_0000, "R9 cleanup clear");
    both(8'h08, 32'h4B00_0000);
    rd(0, 32'h4200_0008, "R9 report beats clear on empty field");

    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule